// File: doc/BRIEF.md
# Two-Level Batched Transmit Buffer

This block sits on the transmit side of a byte stream. It holds 9-bit entries: a data byte plus an end-of-frame mark. A small first-level queue takes entries from two writers. One is a streaming write port driven by a transfer engine. The other is a software path, where a holding register is loaded first and then sent with a push strobe. A burst mover copies entries into a larger second-level store. A consumer drains that store over a valid/ready handshake.

The mover copies whole groups of eight in a single cycle, so the second-level store sees one wide write per group rather than a trickle of single entries. A shorter group is released only when it contains an end-of-frame entry. In that case the mover copies entries up to and including the oldest marked one, and no further.

The block keeps two sticky error flags: one for writes dropped at the first level, and one for reads attempted on an empty second level. It also raises a one-cycle event when a marked entry leaves through the output. A synchronous clear input empties both levels and clears the flags.

Top module: `tx_batch_fifo`

## Requirements
- R1: Entries leave in the order they were accepted. `out_data` carries entry bits 7:0 and `out_eof` carries entry bit 8. When both writers deliver in the same cycle, the streaming-port entry is ordered ahead of the software entry. While `out_valid` is high and `out_ready` is low, the presented entry holds steady.
- R2: When the first level holds at least BURST (8) entries and the second level has at least BURST free slots, the eight oldest entries move in one cycle. The entry that completes the group is stored at one clock edge, and `out_valid` rises after the following edge.
- R3: While the first level holds fewer than BURST entries and none of them has bit 8 set, nothing moves and `out_valid` stays low.
- R4: When the first level holds fewer than BURST entries and at least one of them is marked, the mover copies the oldest entries up to and including the first marked one. Later entries stay behind until they form a full group or a marked entry arrives.
- R5: A move waits until the second level has room for all of the entries it carries. While it waits, no entry is lost.
- R6: `sw_load` copies `sw_wdata` into the holding register. Each cycle with `sw_push` high enqueues exactly one copy of the register. If `sw_load` and `sw_push` are high in the same cycle, the push takes the value that was held before that cycle.
- R7: A write from either port that arrives while the first level is full is dropped, and it sets the sticky flag `ovf_l1`.
- R8: A cycle with `out_ready` high while `out_valid` is low sets the sticky flag `udf_l2`.
- R9: After `rst_n` or `soft_clr`, both levels are empty, `out_valid`, `ovf_l1`, `udf_l2` and `eof_evt` are all low, and entries accepted before the clear never appear at the output.
- R10: `eof_evt` is high for exactly the cycle after each handshake of an entry whose bit 8 is set, and it is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_clr | input | 1 | Synchronous clear of pointers, counts and flags |
| dma_wr | input | 1 | Streaming-port write strobe |
| dma_wdata | input | 9 | Streaming-port entry (bit 8 = end of frame) |
| sw_load | input | 1 | Load software holding register |
| sw_wdata | input | 9 | Value for the software holding register |
| sw_push | input | 1 | Enqueue the software holding register |
| out_valid | output | 1 | Second level has an entry |
| out_ready | input | 1 | Consumer takes the presented entry |
| out_data | output | 8 | Data byte of the presented entry |
| out_eof | output | 1 | End-of-frame mark of the presented entry |
| eof_evt | output | 1 | Pulse after a marked entry leaves |
| ovf_l1 | output | 1 | Sticky first-level overflow |
| udf_l2 | output | 1 | Sticky second-level underflow |

## Verification
The bench keeps the first level at 16 entries and the group size at 8, but builds the second level with only 16 slots. With that depth, two groups fill the second level. Backpressure on the mover, a partial flush that must wait for space, and a completely full first level that drops a write all become reachable within a few dozen cycles. The bench also fills the first level with a partial, marked run behind a full second level. This shows that the mover stops at the marked entry and that the remaining entry waits for a later group.

// File: rtl/tx_batch_fifo.sv
`timescale 1ns/1ps
module tx_batch_fifo #(
  parameter int L1_DEPTH = 16,
  parameter int L2_DEPTH = 64,
  parameter int BURST    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_clr,
  input  logic       dma_wr,
  input  logic [8:0] dma_wdata,
  input  logic       sw_load,
  input  logic [8:0] sw_wdata,
  input  logic       sw_push,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_eof,
  output logic       eof_evt,
  output logic       ovf_l1,
  output logic       udf_l2
);
  // Depths must be powers of two; pointers wrap naturally.
  localparam int A1 = $clog2(L1_DEPTH);
  localparam int A2 = $clog2(L2_DEPTH);
  localparam int C1 = $clog2(L1_DEPTH + 1);
  localparam int C2 = $clog2(L2_DEPTH + 1);
  localparam int CB = $clog2(BURST + 1);
  localparam logic [C1-1:0] L1_FULL = C1'(L1_DEPTH);
  localparam logic [C2-1:0] L2_FULL = C2'(L2_DEPTH);
  localparam logic [CB-1:0] BURST_N = CB'(BURST);

  logic [8:0]    l1_mem [L1_DEPTH];
  logic [8:0]    l2_mem [L2_DEPTH];
  logic [A1-1:0] l1_rp, l1_wp;
  logic [C1-1:0] l1_cnt, l1_free;
  logic [A2-1:0] l2_rp, l2_wp;
  logic [C2-1:0] l2_cnt, l2_free;
  logic [8:0]    sw_reg;
  logic          dma_take, sw_take, pop, found;
  logic [CB-1:0] want, mv;

  assign l1_free   = L1_FULL - l1_cnt;
  assign l2_free   = L2_FULL - l2_cnt;
  assign dma_take  = dma_wr && (l1_free != '0);
  assign sw_take   = sw_push && (l1_free > C1'(dma_take));
  assign out_valid = (l2_cnt != '0);
  assign out_data  = l2_mem[l2_rp][7:0];
  assign out_eof   = l2_mem[l2_rp][8];
  assign pop       = out_valid && out_ready;

  // Group size: a full burst, or a partial run closed by the oldest marked entry.
  always_comb begin
    found = 1'b0;
    want  = '0;
    for (int i = 0; i < BURST; i++) begin
      if (!found && (C1'(i) < l1_cnt) && l1_mem[l1_rp + A1'(i)][8]) begin
        found = 1'b1;
        want  = CB'(i + 1);
      end
    end
    if (l1_cnt >= C1'(BURST)) want = BURST_N;
    mv = (C2'(want) <= l2_free) ? want : '0;
  end

  always_ff @(posedge clk) begin
    if (dma_take) l1_mem[l1_wp] <= dma_wdata;
    if (sw_take)  l1_mem[l1_wp + A1'(dma_take)] <= sw_reg;
    for (int i = 0; i < BURST; i++)
      if (CB'(i) < mv) l2_mem[l2_wp + A2'(i)] <= l1_mem[l1_rp + A1'(i)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sw_reg <= '0;
    else if (sw_load)  sw_reg <= sw_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l1_rp <= '0; l1_wp <= '0; l1_cnt <= '0;
      l2_rp <= '0; l2_wp <= '0; l2_cnt <= '0;
      ovf_l1 <= 1'b0; udf_l2 <= 1'b0; eof_evt <= 1'b0;
    end else if (soft_clr) begin
      l1_rp <= '0; l1_wp <= '0; l1_cnt <= '0;
      l2_rp <= '0; l2_wp <= '0; l2_cnt <= '0;
      ovf_l1 <= 1'b0; udf_l2 <= 1'b0; eof_evt <= 1'b0;
    end else begin
      l1_wp   <= l1_wp + A1'(dma_take) + A1'(sw_take);
      l1_rp   <= l1_rp + A1'(mv);
      l1_cnt  <= l1_cnt + C1'(dma_take) + C1'(sw_take) - C1'(mv);
      l2_wp   <= l2_wp + A2'(mv);
      l2_rp   <= l2_rp + A2'(pop);
      l2_cnt  <= l2_cnt + C2'(mv) - C2'(pop);
      ovf_l1  <= ovf_l1 | (dma_wr & ~dma_take) | (sw_push & ~sw_take);
      udf_l2  <= udf_l2 | (out_ready & ~out_valid);
      eof_evt <= pop & out_eof;
    end
  end
endmodule

// File: rtl/tx_batch_fifo_chk.sv
`timescale 1ns/1ps
module tx_batch_fifo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_clr,
  input logic       dma_wr,
  input logic [8:0] dma_wdata,
  input logic       sw_load,
  input logic [8:0] sw_wdata,
  input logic       sw_push,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_eof,
  input logic       eof_evt,
  input logic       ovf_l1,
  input logic       udf_l2
);
  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !soft_clr) |=> (out_valid && $stable(out_data) && $stable(out_eof))); // R1
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_l1 && !soft_clr) |=> ovf_l1); // R7
  AST_UDF_ON_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !out_valid && !soft_clr) |=> udf_l2); // R8
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (!out_valid && !ovf_l1 && !udf_l2 && !eof_evt)); // R9
  AST_EVT_FOLLOWS_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    eof_evt |-> $past(out_valid && out_ready && out_eof)); // R10
endmodule

bind tx_batch_fifo tx_batch_fifo_chk i_chk (.*);

// File: tb/test_tx_batch_fifo.sv
`timescale 1ns/1ps
module test_tx_batch_fifo;
  logic clk = 1'b0, rst_n = 1'b0, soft_clr = 1'b0;
  logic dma_wr = 1'b0, sw_load = 1'b0, sw_push = 1'b0, out_ready = 1'b0;
  logic [8:0] dma_wdata = '0, sw_wdata = '0;
  logic out_valid, out_eof, eof_evt, ovf_l1, udf_l2;
  logic [7:0] out_data;

  int checks = 0, errors = 0;
  logic [8:0] expq[$];
  bit evt_due = 1'b0;

  always #2.5 clk = ~clk;

  tx_batch_fifo #(.L1_DEPTH(16), .L2_DEPTH(16), .BURST(8)) i_tx_batch_fifo (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
    .dma_wr(dma_wr), .dma_wdata(dma_wdata),
    .sw_load(sw_load), .sw_wdata(sw_wdata), .sw_push(sw_push),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_eof(out_eof),
    .eof_evt(eof_evt), .ovf_l1(ovf_l1), .udf_l2(udf_l2));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push_dma(input logic [8:0] v, input bit keep);
    dma_wr = 1'b1; dma_wdata = v;
    if (keep) expq.push_back(v);
    step();
    dma_wr = 1'b0;
  endtask

  task automatic drain(input int n);
    for (int k = 0; k < n; k++) begin
      out_ready = out_valid;
      step();
    end
    out_ready = 1'b0;
  endtask

  // Monitor: compares every handshake with the scoreboard and tracks the EOF event (R1, R10)
  always @(negedge clk) begin
    if (rst_n) begin
      if (evt_due || eof_evt) check(eof_evt == evt_due, "R10 eof_evt", eof_evt, evt_due);
      evt_due = 1'b0;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) check(1'b0, "R1 unexpected entry", {out_eof, out_data}, 0);
        else begin
          logic [8:0] e;
          e = expq.pop_front();
          check({out_eof, out_data} == e, "R1 entry order/content", {out_eof, out_data}, e);
        end
        if (out_eof) evt_due = 1'b1;
      end
    end
  end

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    check(!out_valid && !ovf_l1 && !udf_l2 && !eof_evt, "R9 reset state",
          {out_valid, ovf_l1, udf_l2, eof_evt}, 0);

    // R3: five unmarked entries stay put
    for (int i = 0; i < 5; i++) push_dma(9'h011 + 9'(i), 1'b1);
    repeat (6) step();
    check(out_valid == 1'b0, "R3 partial group held", out_valid, 0);

    // R2: eighth entry completes a group; visible one edge later
    for (int i = 0; i < 3; i++) push_dma(9'h016 + 9'(i), 1'b1);
    check(out_valid == 1'b0, "R2 not before move edge", out_valid, 0);
    step();
    check(out_valid == 1'b1, "R2 burst visible", out_valid, 1);
    drain(12);
    check(expq.size() == 0 && !out_valid, "R2 all drained", expq.size(), 0);

    // R4 / R10: short marked frame flushes on its own
    push_dma(9'h031, 1'b1); push_dma(9'h032, 1'b1); push_dma(9'h133, 1'b1);
    repeat (2) step();
    check(out_valid == 1'b1, "R4 marked partial released", out_valid, 1);
    drain(8);
    check(expq.size() == 0, "R4 marked frame drained", expq.size(), 0);

    // R5, R6, R1, R4: second level full, partial waits, stops at first mark
    for (int i = 0; i < 16; i++) push_dma(9'h040 + 9'(i), 1'b1);
    step();
    sw_load = 1'b1; sw_wdata = 9'h060; step();
    sw_wdata = 9'h062; sw_push = 1'b1; expq.push_back(9'h060); step();   // R6 push takes old value
    sw_load = 1'b0; dma_wr = 1'b1; dma_wdata = 9'h161;
    expq.push_back(9'h161); expq.push_back(9'h062); step();               // R1 stream port first
    dma_wr = 1'b0; sw_push = 1'b0;
    repeat (5) step();
    check(out_valid && {out_eof, out_data} == 9'h040, "R5 head held while full", {out_eof, out_data}, 9'h040);
    drain(30);
    check(expq.size() == 1 && !out_valid, "R4 stops after first mark", expq.size(), 1);
    for (int i = 0; i < 7; i++) push_dma(9'h070 + 9'(i), 1'b1);
    step();
    drain(12);
    check(expq.size() == 0, "R4 remainder joins next group", expq.size(), 0);

    // R7: overflow of first level
    for (int i = 0; i < 16; i++) push_dma(9'h080 + 9'(i), 1'b1);
    step();
    for (int i = 0; i < 16; i++) push_dma(9'h0A0 + 9'(i), 1'b1);
    check(ovf_l1 == 1'b0, "R7 no overflow at exactly full", ovf_l1, 0);
    push_dma(9'h0FF, 1'b0);
    check(ovf_l1 == 1'b1, "R7 overflow flagged", ovf_l1, 1);
    drain(45);
    check(expq.size() == 0, "R7 dropped entry absent", expq.size(), 0);
    check(ovf_l1 == 1'b1, "R7 flag sticky", ovf_l1, 1);

    // R8: read on empty
    check(udf_l2 == 1'b0, "R8 clear before", udf_l2, 0);
    out_ready = 1'b1; step(); out_ready = 1'b0;
    check(udf_l2 == 1'b1, "R8 underflow flagged", udf_l2, 1);

    // R9: soft clear drops both levels and flags
    for (int i = 0; i < 8; i++) push_dma(9'h0C0 + 9'(i), 1'b0);
    step();
    check(out_valid == 1'b1, "R9 second level loaded", out_valid, 1);
    for (int i = 0; i < 3; i++) push_dma(9'h0D0 + 9'(i), 1'b0);
    soft_clr = 1'b1; step(); soft_clr = 1'b0;
    check(!out_valid && !ovf_l1 && !udf_l2, "R9 clear state", {out_valid, ovf_l1, udf_l2}, 0);
    for (int i = 0; i < 5; i++) push_dma(9'h0E0 + 9'(i), 1'b1);
    repeat (4) step();
    check(out_valid == 1'b0, "R9 first level emptied", out_valid, 0);
    for (int i = 0; i < 3; i++) push_dma(9'h0E5 + 9'(i), 1'b1);
    step();
    drain(12);
    check(expq.size() == 0 && !out_valid, "R9 only post-clear entries", expq.size(), 0);

    repeat (3) step();
    finish_up();
  end
endmodule